// File: doc/BRIEF.md
# Four-Channel Prescaled PWM Waveform Core

This block produces four pulse-width-modulated outputs from one shared period counter. A power-of-two clock divider makes a count enable. A period counter advances on each enable, either climbing from zero to a programmable top and wrapping (edge-aligned) or climbing to the top and descending back to zero (center-aligned). Every channel compares the counter against its own 16-bit compare word. The low 15 bits of that word are the duty. The top bit picks the output polarity.

A sequencer outside the block drives new compare words and a new top value with load strobes. It uses the one-cycle `period_end` strobe to pace its updates. Loaded values wait in shadow registers and are adopted only at the next period boundary, so a change made mid-period can never cut a pulse short. A per-channel disconnect flag holds a pin low at once, whatever its compare word says.

Top module: `pwm_wave_core`

## Requirements
- R1: With `presc_sel` = n (0..7), the counter advances once every 2^n clock cycles, so every period length and high time scales by 2^n.
- R2: In edge-aligned mode (`mode_center` = 0) with top T, the counter runs 0..T and wraps. A period lasts T+1 counts. A channel with duty d (0 < d < T, bit 15 clear) is high for the d counts where the counter is below d.
- R3: In center-aligned mode (`mode_center` = 1) with top T ≥ 1, the counter runs 0,1..T,T-1..1 and then returns to 0. A period lasts 2T counts. A channel with duty d (0 < d < T, bit 15 clear) is high for 2d-1 counts.
- R4: A duty (compare bits 14:0) of 0 gives a fully low output. A duty at or above the active top gives a fully high output. Both assume bit 15 is clear.
- R5: Compare bit 15 set inverts the channel output, so the high time becomes the period minus the R2/R3/R4 value. Bit 15 is never part of the duty.
- R6: A channel with its `ch_disc` bit set drives 0 from the next cycle on, whatever its compare word or polarity.
- R7: After reset the active top is 1000, every compare word is 0, the mode is edge-aligned and all outputs are low. With `presc_sel` = 0 the period is 1001 cycles.
- R8: A value given with `top_load` or `cmp_load`, or a new `mode_center` level, takes effect at the first period boundary after the load cycle. The period already running keeps its old length and duties.
- R9: `period_end` is high for exactly one cycle per period. It is high in the cycle after the counter returns to zero, which is the cycle in which the new values apply.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| presc_sel | input | 3 | Divider code n; the count enable fires every 2^n cycles |
| mode_center | input | 1 | 0 edge-aligned, 1 center-aligned; applied at a boundary |
| top_in | input | 15 | New top value |
| top_load | input | 1 | Captures `top_in` into the top shadow |
| cmp_in | input | 64 | Four compare words; channel k in bits 16k+15:16k; bit 15 of each word is the polarity |
| cmp_load | input | 1 | Captures all four compare words into the shadows |
| ch_disc | input | 4 | Per-channel disconnect; a set bit forces that output low |
| pwm_out | output | 4 | Registered PWM outputs, channel k on bit k |
| period_end | output | 1 | One-cycle strobe marking each period boundary |

## Verification
The assertions assume that every input changes only between active clock edges. They also assume that a top of zero is never loaded, because that would make every count a boundary and keep `period_end` high without a break. The divider check tolerates `presc_sel` changing at any time. The stimulus drives all inputs at falling edges and loads only tops of 8 or more. It measures each period from one `period_end` to the next and throws away the first window after any change, because that window still holds one sample of the old configuration.

// File: rtl/pwmw_pkg.sv
package pwmw_pkg;
  localparam int unsigned NUM_CH   = 4;
  localparam int unsigned CNT_W    = 15;
  localparam int unsigned CMP_W    = CNT_W + 1;
  localparam int unsigned PRE_W    = 3;
  localparam int unsigned TOP_INIT = 1000;

  typedef enum logic {
    MODE_EDGE   = 1'b0,
    MODE_CENTER = 1'b1
  } cnt_mode_e;
endpackage

// File: rtl/pwmw_prescaler.sv
module pwmw_prescaler #(
  parameter int unsigned PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PRE_W-1:0] sel,
  output logic             tick
);
  localparam int unsigned DIV_W = (1 << PRE_W) - 1;

  logic [DIV_W-1:0] div_cnt;
  logic [DIV_W-1:0] mask;

  always_ff @(posedge clk) begin
    if (rst) div_cnt <= '0;
    else     div_cnt <= div_cnt + DIV_W'(1);
  end

  always_comb begin
    mask = (DIV_W'(1) << sel) - DIV_W'(1);
    tick = ((div_cnt & mask) == mask);
  end

  // R1
  tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && sel != '0) |=> (!tick || sel == '0));
endmodule

// File: rtl/pwmw_counter.sv
module pwmw_counter #(
  parameter int unsigned CNT_W    = 15,
  parameter int unsigned TOP_INIT = 1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             mode_center,
  input  logic [CNT_W-1:0] top_in,
  input  logic             top_load,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] top_act,
  output logic             wrap,
  output logic             period_end
);
  import pwmw_pkg::*;

  logic [CNT_W-1:0] top_pend;
  cnt_mode_e        mode_pend, mode_act;
  logic             going_down;
  logic             step_down;

  always_comb begin
    step_down = going_down || (cnt >= top_act);
    if (mode_act == MODE_CENTER)
      wrap = tick && ((top_act == '0) || (step_down && cnt <= CNT_W'(1)));
    else
      wrap = tick && (cnt >= top_act);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      top_pend  <= CNT_W'(TOP_INIT);
      mode_pend <= MODE_EDGE;
    end else begin
      if (top_load) top_pend <= top_in;
      mode_pend <= mode_center ? MODE_CENTER : MODE_EDGE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      going_down <= 1'b0;
      top_act    <= CNT_W'(TOP_INIT);
      mode_act   <= MODE_EDGE;
      period_end <= 1'b0;
    end else begin
      period_end <= wrap;
      if (wrap) begin
        cnt        <= '0;
        going_down <= 1'b0;
        top_act    <= top_pend;
        mode_act   <= mode_pend;
      end else if (tick) begin
        if (mode_act == MODE_CENTER && step_down) begin
          cnt        <= cnt - CNT_W'(1);
          going_down <= 1'b1;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end

  // R8
  top_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(top_act));

  // R2
  edge_step_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && mode_act == MODE_EDGE && !wrap) |=> (cnt == $past(cnt) + CNT_W'(1)));

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt));

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= top_act);

  // R9
  pe_zero_chk: assert property (@(posedge clk) disable iff (rst)
    period_end |-> cnt == '0);
endmodule

// File: rtl/pwmw_channel.sv
module pwmw_channel #(
  parameter int unsigned CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrap,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] top_act,
  input  logic [CNT_W:0]   cmp_in,
  input  logic             cmp_load,
  input  logic             disc,
  output logic             pwm
);
  localparam int unsigned CMP_W = CNT_W + 1;

  logic [CMP_W-1:0] cmp_pend, cmp_act;
  logic [CNT_W-1:0] duty;
  logic             invert;
  logic             raw;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_pend <= '0;
      cmp_act  <= '0;
    end else begin
      if (cmp_load) cmp_pend <= cmp_in;
      if (wrap)     cmp_act  <= cmp_pend;
    end
  end

  always_comb begin
    duty   = cmp_act[CNT_W-1:0];
    invert = cmp_act[CNT_W];
    if (duty == '0)            raw = 1'b0;
    else if (duty >= top_act)  raw = 1'b1;
    else                       raw = (cnt < duty);
  end

  always_ff @(posedge clk) begin
    if (rst) pwm <= 1'b0;
    else     pwm <= disc ? 1'b0 : (raw ^ invert);
  end

  // R6
  disc_low_chk: assert property (@(posedge clk) disable iff (rst)
    disc |=> !pwm);

  // R8
  cmp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(cmp_act));

  // R4
  zero_off_chk: assert property (@(posedge clk) disable iff (rst)
    (cmp_act == '0) |=> !pwm);
endmodule

// File: rtl/pwm_wave_core.sv
module pwm_wave_core
  import pwmw_pkg::*;
#(
  parameter int unsigned N_CH   = NUM_CH,
  parameter int unsigned C_W    = CNT_W,
  parameter int unsigned P_W    = PRE_W,
  parameter int unsigned TOP_RV = TOP_INIT
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [P_W-1:0]          presc_sel,
  input  logic                    mode_center,
  input  logic [C_W-1:0]          top_in,
  input  logic                    top_load,
  input  logic [N_CH*(C_W+1)-1:0] cmp_in,
  input  logic                    cmp_load,
  input  logic [N_CH-1:0]         ch_disc,
  output logic [N_CH-1:0]         pwm_out,
  output logic                    period_end
);
  localparam int unsigned WORD_W = C_W + 1;

  logic           tick;
  logic           wrap;
  logic [C_W-1:0] cnt;
  logic [C_W-1:0] top_act;

  pwmw_prescaler #(.PRE_W(P_W)) u_presc (
    .clk  (clk),
    .rst  (rst),
    .sel  (presc_sel),
    .tick (tick)
  );

  pwmw_counter #(.CNT_W(C_W), .TOP_INIT(TOP_RV)) u_cnt (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .mode_center (mode_center),
    .top_in      (top_in),
    .top_load    (top_load),
    .cnt         (cnt),
    .top_act     (top_act),
    .wrap        (wrap),
    .period_end  (period_end)
  );

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    pwmw_channel #(.CNT_W(C_W)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .wrap     (wrap),
      .cnt      (cnt),
      .top_act  (top_act),
      .cmp_in   (cmp_in[k*WORD_W +: WORD_W]),
      .cmp_load (cmp_load),
      .disc     (ch_disc[k]),
      .pwm      (pwm_out[k])
    );
  end
endmodule

// File: tb/sim_pwm_wave_core.sv
module sim_pwm_wave_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  presc_sel = '0;
  logic        mode_center = 1'b0;
  logic [14:0] top_in = '0;
  logic        top_load = 1'b0;
  logic [63:0] cmp_in = '0;
  logic        cmp_load = 1'b0;
  logic [3:0]  ch_disc = '0;
  logic [3:0]  pwm_out;
  logic        period_end;

  int n_tests = 0;
  int n_fail  = 0;
  int per;
  int hi [4];
  int cyc = 0;

  pwm_wave_core u0 (
    .clk(clk), .rst(rst), .presc_sel(presc_sel), .mode_center(mode_center),
    .top_in(top_in), .top_load(top_load), .cmp_in(cmp_in), .cmp_load(cmp_load),
    .ch_disc(ch_disc), .pwm_out(pwm_out), .period_end(period_end)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 150000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sync_pe();
    do @(negedge clk); while (!period_end);
  endtask

  // Starts at a falling edge where period_end is high; ends at the next one.
  task automatic measure();
    per = 0;
    for (int k = 0; k < 4; k++) hi[k] = 0;
    do begin
      per++;
      for (int k = 0; k < 4; k++) hi[k] += int'(pwm_out[k]);
      @(negedge clk);
      top_load = 1'b0;
      cmp_load = 1'b0;
    end while (!period_end);
  endtask

  task automatic set_cmp(input logic [15:0] w0, input logic [15:0] w1,
                         input logic [15:0] w2, input logic [15:0] w3);
    cmp_in = {w3, w2, w1, w0};
  endtask

  task automatic apply(input logic [14:0] t);
    top_in   = t;
    top_load = 1'b1;
    cmp_load = 1'b1;
    @(negedge clk);
    top_load = 1'b0;
    cmp_load = 1'b0;
    sync_pe();
    measure();  // first window still holds one old sample
    measure();
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (5) @(negedge clk);
    check("R7 pwm in reset", int'(pwm_out), 0);
    check("R7 period_end in reset", int'(period_end), 0);
    rst = 1'b0;
    sync_pe();
    @(negedge clk);
    check("R9 strobe single cycle", int'(period_end), 0);
    sync_pe();
    measure();
    check("R7 default period", per, 1001);
    check("R7 default compare ch0", hi[0], 0);
    check("R7 default compare ch3", hi[3], 0);
  endtask

  task automatic t_edge();
    mode_center = 1'b0;
    set_cmp(16'd5, 16'd12, 16'd0, 16'd20);
    apply(15'd20);
    check("R2 edge period", per, 21);
    check("R2 edge duty 5", hi[0], 5);
    check("R2 edge duty 12", hi[1], 12);
    check("R4 duty zero off", hi[2], 0);
    check("R4 duty at top on", hi[3], 21);
  endtask

  task automatic t_polarity();
    set_cmp(16'h8005, 16'h8000, 16'h800C, 16'h801E);
    apply(15'd20);
    check("R5 inverted duty 5", hi[0], 16);
    check("R5 inverted zero", hi[1], 21);
    check("R5 inverted duty 12", hi[2], 9);
    check("R5 inverted above top", hi[3], 0);
  endtask

  task automatic t_center();
    mode_center = 1'b1;
    set_cmp(16'd3, 16'd7, 16'd0, 16'd10);
    apply(15'd10);
    check("R3 center period", per, 20);
    check("R3 center duty 3", hi[0], 5);
    check("R3 center duty 7", hi[1], 13);
    check("R4 center zero", hi[2], 0);
    check("R4 center at top", hi[3], 20);
  endtask

  task automatic t_presc();
    mode_center = 1'b0;
    presc_sel = 3'd2;
    set_cmp(16'd4, 16'h8004, 16'd0, 16'd9);
    apply(15'd9);
    check("R1 scaled period", per, 40);
    check("R1 scaled duty", hi[0], 16);
    check("R1 scaled inverted", hi[1], 24);
    check("R1 scaled full on", hi[3], 40);
    presc_sel = 3'd0;
  endtask

  task automatic t_disc();
    ch_disc = 4'b0101;
    set_cmp(16'h8000, 16'h8000, 16'h8000, 16'h8000);
    apply(15'd20);
    check("R6 disconnected ch0", hi[0], 0);
    check("R6 connected ch1", hi[1], 21);
    check("R6 disconnected ch2", hi[2], 0);
    check("R6 connected ch3", hi[3], 21);
    ch_disc = 4'b0000;
  endtask

  task automatic t_reload();
    set_cmp(16'd5, 16'd0, 16'd0, 16'd0);
    apply(15'd20);
    top_in = 15'd8;
    set_cmp(16'd3, 16'd0, 16'd0, 16'd0);
    top_load = 1'b1;
    cmp_load = 1'b1;
    measure();
    check("R8 running period keeps old top", per, 21);
    check("R8 running period keeps old duty", hi[0], 5);
    measure();
    check("R8 new top at boundary", per, 9);
    check("R8 new duty at boundary", hi[0], 3);
  endtask

  initial begin
    t_reset();
    t_edge();
    t_polarity();
    t_center();
    t_presc();
    t_disc();
    t_reload();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule